// File: doc/BRIEF.md
# Parallel PRBS word generator

This block turns a linear feedback shift register into a byte-wide pseudo-random stream. On every clock it advances the register by eight bit-steps at once through unrolled logic, and it registers the eight bits that those steps produce as one output word. The register length (the polynomial order) is a parameter. A table of common maximal-length polynomials picks the feedback tap.

A synchronous, active-high reset loads a non-zero seed, so the same word sequence always follows a reset. A test can assert the error-injection input in any cycle. The word captured at that edge then leaves with its least significant bit inverted. The register state does not see the injection, so a downstream checker finds exactly one bad word and then stays locked.

Top module: `prbs_word_gen`

## Requirements
- R1: The parameter ORDER selects the polynomial with feedback tap T: order 5 uses x^5+x^3+1 (T=3), 7 uses x^7+x^6+1 (T=6), 9 uses x^9+x^5+1 (T=5), 11 uses T=9, 15 uses T=14, 20 uses T=17, 23 uses T=18 and 31 uses T=28. Both order 5 and order 9 work.
- R2: While reset is sampled high, the output word registers as 0x00. The inject input has no effect during reset.
- R3: With ORDER=5 and seed 0x1F, the first four words after reset are released are 0xC7, 0xAE, 0x90 and 0xE6, one per clock, in that order.
- R4: Reset is synchronous and active high and loads the seed into the register state. Asserting reset again in the middle of a run restarts the word sequence from its first word.
- R5: The bit stream follows b[n] = b[n-ORDER] xor b[n-T], with b[i] taken from seed bit i for i < ORDER. Word k after reset holds bit b[ORDER-T+8k+j] at position j, so the earliest bit is the LSB. A new word appears on every clock edge.
- R6: When inject_error is high at a clock edge outside reset, the word registered at that edge has bit 0 inverted and bits 7..1 correct. This also holds for back-to-back cycles.
- R7: Injection does not change the register state. The word after an injected one is the correct next word of the sequence.
- R8: If the register state is ever all zeros, the seed is reloaded on the next edge. With a non-zero seed, order 5 never emits the word 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset; loads the seed |
| inject_error | input | 1 | Inverts bit 0 of the word captured at this edge |
| prbs_word | output | WORD_W (8) | Registered pseudo-random output word |

## Verification
The assertions assume that the seed parameter is non-zero and that rst is a clean level sampled at the rising edge. They make no assumption about when inject_error toggles. Under these assumptions, reset always leaves the seed in the state, and the zero-recovery rule never triggers in normal running. The stimulus changes every input on the falling edge and holds reset for at least one full cycle. It injects errors singly, periodically and in a back-to-back burst, and it also raises inject during reset. Both supported orders run side by side with non-zero seeds.

// File: rtl/prbs_gen_pkg.sv
package prbs_gen_pkg;

  // Inner feedback tap (exponent) of the maximal-length polynomial
  // x^order + x^tap + 1 for each supported register length.
  function automatic int prbs_tap(input int order);
    case (order)
      5:       return 3;
      7:       return 6;
      9:       return 5;
      11:      return 9;
      15:      return 14;
      20:      return 17;
      23:      return 18;
      31:      return 28;
      default: return order - 1;
    endcase
  endfunction

endpackage

// File: rtl/prbs_unroll.sv
// Combinational advance of the register by WORD_W single-bit steps.
// Stage g holds the state after g steps; each step emits the bit at the
// inner tap and shifts in the feedback bit at the top.
module prbs_unroll #(
  parameter int ORDER  = 5,
  parameter int TAP    = 3,
  parameter int WORD_W = 8
) (
  input  logic [ORDER-1:0]  state_i,
  output logic [ORDER-1:0]  state_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int SRC    = ORDER - TAP;
  localparam int PREFIX = (TAP < WORD_W) ? TAP : WORD_W;

  logic [ORDER-1:0] stage [0:WORD_W];

  assign stage[0] = state_i;

  for (genvar g = 0; g < WORD_W; g++) begin : g_step
    assign word_o[g]    = stage[g][SRC];
    assign stage[g+1]   = {stage[g][0] ^ stage[g][SRC], stage[g][ORDER-1:1]};
  end

  assign state_o = stage[WORD_W];

  // The first bits of a word have not yet passed through feedback, so they
  // must come straight from the current state (R5).
  for (genvar j = 0; j < PREFIX; j++) begin : g_chk
    always_comb begin
      if (!$isunknown(state_i)) begin
        p_word_prefix_r5: assert (word_o[j] == state_i[SRC+j]);
      end
    end
  end

endmodule

// File: rtl/prbs_state_reg.sv
// Register state with seed load on reset and recovery from the lock-up state.
module prbs_state_reg #(
  parameter int               ORDER  = 5,
  parameter logic [ORDER-1:0] SEED_V = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ORDER-1:0] next_i,
  output logic [ORDER-1:0] state_o
);

  logic [ORDER-1:0] state_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEED_V;
    end else if (state_q == '0) begin
      state_q <= SEED_V;
    end else begin
      state_q <= next_i;
    end
  end

  assign state_o = state_q;

  // R4: the first cycle after reset starts from the seed
  p_seed_load_r4: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state_q == SEED_V));

  // R8: an all-zero state never persists
  p_zero_recover_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == '0) |=> (state_q == SEED_V));

endmodule

// File: rtl/prbs_word_reg.sv
// Output word register with the single-bit corruption path.
module prbs_word_reg #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              flip_i,
  output logic [WORD_W-1:0] word_o
);

  localparam logic [WORD_W-1:0] FLIP_MASK = WORD_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
    end else if (flip_i) begin
      word_o <= word_i ^ FLIP_MASK;
    end else begin
      word_o <= word_i;
    end
  end

  // R2: a reset cycle leaves a zero word behind
  p_reset_out_zero_r2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (word_o == '0));

  // R6: an injected cycle differs from the generated word in its LSB
  p_inject_lsb_r6: assert property (@(posedge clk) disable iff (rst)
    flip_i |=> (word_o[0] != $past(word_i[0])));

endmodule

// File: rtl/prbs_word_gen.sv
module prbs_word_gen
  import prbs_gen_pkg::*;
#(
  parameter int          ORDER  = 5,
  parameter logic [31:0] SEED   = 32'h0000_001F,
  parameter int          WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inject_error,
  output logic [WORD_W-1:0] prbs_word
);

  localparam int               TAP    = prbs_tap(ORDER);
  localparam logic [ORDER-1:0] SEED_V = SEED[ORDER-1:0];

  logic [ORDER-1:0]  cur_state;
  logic [ORDER-1:0]  adv_state;
  logic [WORD_W-1:0] raw_word;

  prbs_state_reg #(
    .ORDER  (ORDER),
    .SEED_V (SEED_V)
  ) u_state (
    .clk     (clk),
    .rst     (rst),
    .next_i  (adv_state),
    .state_o (cur_state)
  );

  prbs_unroll #(
    .ORDER  (ORDER),
    .TAP    (TAP),
    .WORD_W (WORD_W)
  ) u_unroll (
    .state_i (cur_state),
    .state_o (adv_state),
    .word_o  (raw_word)
  );

  prbs_word_reg #(
    .WORD_W (WORD_W)
  ) u_word (
    .clk    (clk),
    .rst    (rst),
    .word_i (raw_word),
    .flip_i (inject_error),
    .word_o (prbs_word)
  );

endmodule

// File: tb/prbs_word_gen_tb_top.sv
`timescale 1ns/1ps
module prbs_word_gen_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst  = 1'b1;
  logic       inj5 = 1'b0;
  logic       inj9 = 1'b0;
  logic [7:0] w5;
  logic [7:0] w9;

  prbs_word_gen #(.ORDER(5), .SEED(32'h1F), .WORD_W(8)) dut_i (
    .clk(clk), .rst(rst), .inject_error(inj5), .prbs_word(w5));

  prbs_word_gen #(.ORDER(9), .SEED(32'h0A5), .WORD_W(8)) dut9_i (
    .clk(clk), .rst(rst), .inject_error(inj9), .prbs_word(w9));

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  bit s5 [0:4095];
  bit s9 [0:4095];

  // Reference streams straight from the R5 recurrence
  task automatic build_streams();
    for (int i = 0; i < 5; i++) s5[i] = 1'((32'h1F >> i) & 1);
    for (int n = 5; n < 4096; n++) s5[n] = s5[n-5] ^ s5[n-3];
    for (int i = 0; i < 9; i++) s9[i] = 1'((32'h0A5 >> i) & 1);
    for (int n = 9; n < 4096; n++) s9[n] = s9[n-9] ^ s9[n-5];
  endtask

  function automatic logic [7:0] exp5(int k);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[j] = s5[2 + 8*k + j];
    return r;
  endfunction

  function automatic logic [7:0] exp9(int k);
    logic [7:0] r;
    for (int j = 0; j < 8; j++) r[j] = s9[4 + 8*k + j];
    return r;
  endfunction

  function automatic bit pat5(int k);
    return (k % 7 == 3) || (k >= 100 && k < 104);
  endfunction

  function automatic bit pat9(int k);
    return (k % 5 == 1);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic check_bit(string req, bit ok);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0 expected 1", req);
    end
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] ref3 [0:3];
    ref3[0] = 8'hC7; ref3[1] = 8'hAE; ref3[2] = 8'h90; ref3[3] = 8'hE6;
    build_streams();

    // R2: reset state, with inject raised during reset
    repeat (2) @(negedge clk);
    inj5 = 1'b1; inj9 = 1'b1;
    @(negedge clk);
    check("R2 order5 reset word", w5, 8'h00);
    check("R2 order9 reset word", w9, 8'h00);
    inj5 = 1'b0; inj9 = 1'b0;
    rst = 1'b0;

    // R3 / R1: known order-5 words, plus order-9 words
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R3 order5 known word", w5, ref3[k]);
      check("R1 order9 word", w9, exp9(k));
    end

    // R5 / R6 / R7 / R8: long run with single and burst injection
    for (int k = 4; k < 250; k++) begin
      inj5 = pat5(k);
      inj9 = pat9(k);
      @(negedge clk);
      if (pat5(k)) check("R6 order5 injected word", w5, exp5(k) ^ 8'h01);
      else if (pat5(k-1)) check("R7 order5 word after inject", w5, exp5(k));
      else check("R5 order5 word", w5, exp5(k));
      if (pat9(k)) check("R6 order9 injected word", w9, exp9(k) ^ 8'h01);
      else check("R7 order9 word", w9, exp9(k));
      if (!pat5(k)) check_bit("R8 order5 word never zero", w5 != 8'h00);
    end
    inj5 = 1'b0; inj9 = 1'b0;

    // R4: reset in mid-run restarts the sequence from the seed
    rst = 1'b1;
    @(negedge clk);
    check("R4 order5 word in reset", w5, 8'h00);
    check("R4 order9 word in reset", w9, 8'h00);
    rst = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check("R4 order5 restart word", w5, exp5(k));
      check("R4 order9 restart word", w9, exp9(k));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule